// File: doc/BRIEF.md
# External Pin Interrupt Controller

This block watches two asynchronous interrupt pins on behalf of a small 8-bit processor core. Each pin is brought into the clock domain by a synchronizer and then judged according to a per-channel sense setting: rising edge, falling edge, low level, or off. In the edge modes a qualifying transition latches a pending flag. In low-level mode no flag is kept, and the request simply follows the pin.

Software reaches two byte-wide registers over a plain address/read/write bus. The enable register decides which channels may interrupt. The pending register shows latched edges, and software clears a bit by writing a one to it. A channel's request is passed to the core only when its enable bit and the global interrupt-enable input are both set. The block then presents a vector number to the core. When the core acknowledges, the pending flag of the vectored channel is cleared. The pin value is used as sampled, so a pin that the port drives as an output still triggers.

Top module: `extint_ctrl`

## Requirements
- R1: After reset the enable register and the pending register both read 0x00, irq_req is 0 and irq_vec is 0.
- R2: The enable register is at bus address 0x3B. Bit 7 enables channel 1 and bit 6 enables channel 0. Bits 5..0 read as zero, and writes to them are ignored.
- R3: The pending register is at bus address 0x3A. Bit 7 is the channel 1 flag and bit 6 is the channel 0 flag. Bits 5..0 read as zero.
- R4: Sense codes per channel, in 2 bits, are 00 low level, 01 off, 10 falling edge and 11 rising edge. In the edge modes a qualifying pin transition sets that channel's pending flag, and the flag is readable by the third rising clock edge after the pin change.
- R5: With sense 00 the channel's pending flag stays zero. The channel requests for as long as its synchronized pin is low and its enable bit is set.
- R6: With sense 01 pin activity neither sets the flag nor raises a request.
- R7: irq_req is 1 only when some channel has an active condition (a set flag, or a low pin in level mode), that channel's enable bit is 1, and gie is 1.
- R8: Channel 0 uses vector 1 and channel 1 uses vector 2. When both request, channel 0 wins. irq_vec is 0 whenever irq_req is 0.
- R9: An irq_ack pulse clears the pending flag of the channel named by irq_vec.
- R10: Writing a one to a pending-register bit clears that flag. Writing a zero to it has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_in | input | 2 | Asynchronous interrupt pins, bit c is channel c |
| sense_cfg | input | 4 | Sense code, bits [2c+1:2c] for channel c |
| bus_addr | input | 6 | I/O register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, zero when bus_rd is low |
| gie | input | 1 | Global interrupt enable |
| irq_req | output | 1 | Interrupt request to the core |
| irq_vec | output | 2 | Vector number of the winning channel |
| irq_ack | input | 1 | Core acknowledge of the vectored interrupt |

## Verification
The checker assumes that the core raises irq_ack only while irq_req is high, so that irq_vec names a real channel. It also assumes that a bus cycle never asserts read and write together. The flag-clearing properties hold only in cycles where no new edge arrives on the same channel, because a fresh edge takes priority over a clear. The bench drives acknowledges only after confirming a request. It changes pins only when the bus and acknowledge are idle, and it waits four clocks after each pin change, so no edge lands in the same cycle as a clear.

// File: rtl/extint_pkg.sv
package extint_pkg;
   typedef enum logic [1:0] {
      SNS_LOW  = 2'b00,
      SNS_OFF  = 2'b01,
      SNS_FALL = 2'b10,
      SNS_RISE = 2'b11
   } sense_e;
endpackage

// File: rtl/extint_sync.sv
module extint_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   generate
      if (STAGES < 2) begin : g_bad
         $error("extint_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= {STAGES{RST_VAL}};
      else        chain_q <= {chain_q[STAGES-2:0], d};
   end

   assign q = chain_q[STAGES-1];
endmodule

// File: rtl/extint_chan.sv
module extint_chan
   import extint_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       pin_s,
   input  logic [1:0] sense,
   input  logic       clr_sw,
   input  logic       clr_hw,
   output logic       flag,
   output logic       level_act,
   output logic       set_ev
);
   logic   prev_q;
   logic   flag_q;
   logic   rise, fall;
   sense_e mode;

   assign mode = sense_e'(sense);
   assign rise = pin_s & ~prev_q;
   assign fall = ~pin_s & prev_q;

   always_comb begin
      case (mode)
         SNS_RISE: set_ev = rise;
         SNS_FALL: set_ev = fall;
         default:  set_ev = 1'b0;
      endcase
   end

   assign level_act = (mode == SNS_LOW) & ~pin_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= 1'b1;
         flag_q <= 1'b0;
      end else begin
         prev_q <= pin_s;
         if (mode == SNS_LOW)        flag_q <= 1'b0;
         else if (set_ev)            flag_q <= 1'b1;
         else if (clr_sw || clr_hw)  flag_q <= 1'b0;
      end
   end

   assign flag = flag_q;
endmodule

// File: rtl/extint_prio.sv
module extint_prio #(
   parameter int NUM_CH = 2,
   localparam int VEC_W = $clog2(NUM_CH + 1)
) (
   input  logic [NUM_CH-1:0] req,
   output logic              any,
   output logic [VEC_W-1:0]  vec
);
   always_comb begin
      vec = '0;
      for (int c = NUM_CH - 1; c >= 0; c--) begin
         if (req[c]) vec = VEC_W'(c + 1);
      end
   end

   assign any = |req;
endmodule

// File: rtl/extint_ctrl.sv
module extint_ctrl #(
   parameter int               NUM_CH      = 2,
   parameter int               DATA_W      = 8,
   parameter int               ADDR_W      = 6,
   parameter int               SYNC_STAGES = 2,
   parameter logic [ADDR_W-1:0] MASK_ADDR  = 6'h3B,
   parameter logic [ADDR_W-1:0] FLAG_ADDR  = 6'h3A,
   localparam int              VEC_W       = $clog2(NUM_CH + 1),
   localparam int              BASE        = DATA_W - NUM_CH
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_CH-1:0]    pin_in,
   input  logic [2*NUM_CH-1:0]  sense_cfg,
   input  logic [ADDR_W-1:0]    bus_addr,
   input  logic                 bus_wr,
   input  logic                 bus_rd,
   input  logic [DATA_W-1:0]    bus_wdata,
   output logic [DATA_W-1:0]    bus_rdata,
   input  logic                 gie,
   output logic                 irq_req,
   output logic [VEC_W-1:0]     irq_vec,
   input  logic                 irq_ack
);
   generate
      if (NUM_CH < 1 || NUM_CH >= DATA_W) begin : g_bad_ch
         $error("extint_ctrl: NUM_CH must be in 1..DATA_W-1");
      end
      if (MASK_ADDR == FLAG_ADDR) begin : g_bad_addr
         $error("extint_ctrl: register addresses must differ");
      end
   endgenerate

   logic [NUM_CH-1:0] mask_q;
   logic [NUM_CH-1:0] flag_q;
   logic [NUM_CH-1:0] set_ev;
   logic [NUM_CH-1:0] level_act;
   logic [NUM_CH-1:0] pin_s;
   logic [NUM_CH-1:0] chan_req;
   logic              wr_mask, wr_flag;
   logic              unused_wdata;

   assign wr_mask      = bus_wr && (bus_addr == MASK_ADDR);
   assign wr_flag      = bus_wr && (bus_addr == FLAG_ADDR);
   assign unused_wdata = ^bus_wdata[BASE-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       mask_q <= '0;
      else if (wr_mask) mask_q <= bus_wdata[DATA_W-1:BASE];
   end

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      logic ack_hit;
      assign ack_hit = irq_ack && (irq_vec == VEC_W'(c + 1));

      extint_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
         .clk   (clk),
         .rst_n (rst_n),
         .d     (pin_in[c]),
         .q     (pin_s[c])
      );

      extint_chan u_chan (
         .clk       (clk),
         .rst_n     (rst_n),
         .pin_s     (pin_s[c]),
         .sense     (sense_cfg[2*c +: 2]),
         .clr_sw    (wr_flag && bus_wdata[BASE + c]),
         .clr_hw    (ack_hit),
         .flag      (flag_q[c]),
         .level_act (level_act[c]),
         .set_ev    (set_ev[c])
      );

      assign chan_req[c] = gie && mask_q[c] && (flag_q[c] || level_act[c]);
   end

   extint_prio #(.NUM_CH(NUM_CH)) u_prio (
      .req (chan_req),
      .any (irq_req),
      .vec (irq_vec)
   );

   always_comb begin
      bus_rdata = '0;
      if (bus_rd) begin
         if (bus_addr == MASK_ADDR)      bus_rdata[DATA_W-1:BASE] = mask_q;
         else if (bus_addr == FLAG_ADDR) bus_rdata[DATA_W-1:BASE] = flag_q;
      end
   end
endmodule

// File: rtl/extint_ctrl_chk.sv
module extint_ctrl_chk #(
   parameter int               NUM_CH    = 2,
   parameter int               DATA_W    = 8,
   parameter int               ADDR_W    = 6,
   parameter logic [ADDR_W-1:0] FLAG_ADDR = 6'h3A,
   localparam int              VEC_W     = $clog2(NUM_CH + 1),
   localparam int              BASE      = DATA_W - NUM_CH
) (
   input logic                clk,
   input logic                rst_n,
   input logic                gie,
   input logic                irq_req,
   input logic [VEC_W-1:0]    irq_vec,
   input logic                irq_ack,
   input logic                bus_wr,
   input logic                bus_rd,
   input logic [ADDR_W-1:0]   bus_addr,
   input logic [NUM_CH-1:0]   wdata_hi,
   input logic [BASE-1:0]     rdata_lo,
   input logic [2*NUM_CH-1:0] sense_cfg,
   input logic [NUM_CH-1:0]   flag_q,
   input logic [NUM_CH-1:0]   set_ev
);
   AST_REQ_NEEDS_GIE: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req |-> gie); // R7

   AST_IDLE_VEC_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_req |-> (irq_vec == '0)); // R8

   AST_REQ_VEC_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req |-> (irq_vec != '0)); // R8

   AST_RSVD_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rd |-> (rdata_lo == '0)); // R2

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch_chk
      AST_LEVEL_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
         (sense_cfg[2*c +: 2] == 2'b00) |=> !flag_q[c]); // R5

      AST_EDGE_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
         set_ev[c] |=> flag_q[c]); // R4

      AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
         (irq_ack && irq_vec == VEC_W'(c + 1) && !set_ev[c]) |=> !flag_q[c]); // R9

      AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
         (bus_wr && bus_addr == FLAG_ADDR && wdata_hi[c] && !set_ev[c]) |=> !flag_q[c]); // R10

      AST_OFF_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
         (sense_cfg[2*c +: 2] == 2'b01) |-> !set_ev[c]); // R6
   end
endmodule

bind extint_ctrl extint_ctrl_chk #(
   .NUM_CH    (NUM_CH),
   .DATA_W    (DATA_W),
   .ADDR_W    (ADDR_W),
   .FLAG_ADDR (FLAG_ADDR)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .gie       (gie),
   .irq_req   (irq_req),
   .irq_vec   (irq_vec),
   .irq_ack   (irq_ack),
   .bus_wr    (bus_wr),
   .bus_rd    (bus_rd),
   .bus_addr  (bus_addr),
   .wdata_hi  (bus_wdata[DATA_W-1:BASE]),
   .rdata_lo  (bus_rdata[BASE-1:0]),
   .sense_cfg (sense_cfg),
   .flag_q    (flag_q),
   .set_ev    (set_ev)
);

// File: tb/tb_extint_ctrl.sv
module tb_extint_ctrl;
   localparam logic [5:0] A_MASK = 6'h3B;
   localparam logic [5:0] A_FLAG = 6'h3A;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] pin_in = 2'b10;
   logic [3:0] sense_cfg = 4'b10_11;
   logic [5:0] bus_addr = '0;
   logic       bus_wr = 1'b0;
   logic       bus_rd = 1'b0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata;
   logic       gie = 1'b0;
   logic       irq_req;
   logic [1:0] irq_vec;
   logic       irq_ack = 1'b0;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   typedef struct {
      logic       req;
      logic [1:0] vec;
      logic [7:0] rd;
      string      tag;
   } exp_t;

   exp_t exp_q[$];
   event chk_ev;

   always #10 clk = ~clk;

   extint_ctrl dut (
      .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .sense_cfg(sense_cfg),
      .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .gie(gie),
      .irq_req(irq_req), .irq_vec(irq_vec), .irq_ack(irq_ack)
   );

   // monitor: pops one expected item per event and compares outputs
   initial begin
      forever begin
         @(chk_ev);
         while (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            n_checks++;
            if (irq_req !== e.req || irq_vec !== e.vec || bus_rdata !== e.rd) begin
               n_fail++;
               $display("FAIL %s: req=%0b vec=%0d rd=%02h expected req=%0b vec=%0d rd=%02h",
                        e.tag, irq_req, irq_vec, bus_rdata, e.req, e.vec, e.rd);
            end
         end
      end
   end

   task automatic expect_out(input logic [5:0] a, input logic req, input logic [1:0] vec,
                             input logic [7:0] rd, input string tag);
      exp_t e;
      @(negedge clk);
      bus_addr = a;
      bus_rd   = 1'b1;
      e.req = req; e.vec = vec; e.rd = rd; e.tag = tag;
      exp_q.push_back(e);
      #2 -> chk_ev;
      #2 bus_rd = 1'b0;
   endtask

   task automatic bus_write(input logic [5:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0; bus_wdata = '0;
   endtask

   task automatic settle();
      repeat (4) @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      settle();
      expect_out(A_FLAG, 1'b0, 2'd0, 8'h00, "R1 flags after reset");
      expect_out(A_MASK, 1'b0, 2'd0, 8'h00, "R1 mask after reset");

      bus_write(A_MASK, 8'hFF);
      expect_out(A_MASK, 1'b0, 2'd0, 8'hC0, "R2 mask reserved bits");

      // ch0 rising, gie low
      @(negedge clk); pin_in[0] = 1'b1;
      settle();
      expect_out(A_FLAG, 1'b0, 2'd0, 8'h40, "R4 rising sets flag0, R3 layout, R7 gie off");

      gie = 1'b1;
      expect_out(A_FLAG, 1'b1, 2'd1, 8'h40, "R7 R8 ch0 vector 1");

      // ch1 falling
      @(negedge clk); pin_in[1] = 1'b0;
      settle();
      expect_out(A_FLAG, 1'b1, 2'd1, 8'hC0, "R4 falling sets flag1, R8 ch0 priority");

      @(negedge clk); irq_ack = 1'b1;
      @(negedge clk); irq_ack = 1'b0;
      expect_out(A_FLAG, 1'b1, 2'd2, 8'h80, "R9 ack clears ch0, R8 ch1 vector 2");

      bus_write(A_FLAG, 8'h00);
      expect_out(A_FLAG, 1'b1, 2'd2, 8'h80, "R10 writing zero no effect");
      bus_write(A_FLAG, 8'h80);
      expect_out(A_FLAG, 1'b0, 2'd0, 8'h00, "R10 write one clears flag1");

      // mask off: flag latches but no request
      bus_write(A_MASK, 8'h00);
      @(negedge clk); pin_in[0] = 1'b0;
      settle();
      @(negedge clk); pin_in[0] = 1'b1;
      settle();
      expect_out(A_FLAG, 1'b0, 2'd0, 8'h40, "R7 masked channel no request");
      bus_write(A_FLAG, 8'h40);

      // level mode ch0
      bus_write(A_MASK, 8'hC0);
      @(negedge clk); sense_cfg[1:0] = 2'b00;
      settle();
      expect_out(A_FLAG, 1'b0, 2'd0, 8'h00, "R5 level pin high no request");
      @(negedge clk); pin_in[0] = 1'b0;
      settle();
      expect_out(A_FLAG, 1'b1, 2'd1, 8'h00, "R5 level low requests, flag zero");
      gie = 1'b0;
      expect_out(A_FLAG, 1'b0, 2'd0, 8'h00, "R7 level request gated by gie");
      gie = 1'b1;
      @(negedge clk); pin_in[0] = 1'b1;
      settle();
      expect_out(A_FLAG, 1'b0, 2'd0, 8'h00, "R5 level released");

      // ch1 off mode
      @(negedge clk); sense_cfg[3:2] = 2'b01;
      @(negedge clk); pin_in[1] = 1'b1;
      settle();
      @(negedge clk); pin_in[1] = 1'b0;
      settle();
      expect_out(A_FLAG, 1'b0, 2'd0, 8'h00, "R6 off mode ignores pin");

      settle();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      #(200000 * 20);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: run did not complete, expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end
endmodule